// File: doc/BRIEF.md
# Stop-Recovery Clock Switchover

This block decides where the system clock comes from when the chip wakes from its low-power stop state. The crystal is switched off for the whole stop period. When stop ends, the crystal needs a long start-up interval before it can be trusted. A software-set bit selects one of two behaviours for that interval:

- **Ring mode:** the CPU resumes at once on a fast internal ring oscillator.
- **Hold mode:** execution is frozen until the interval has elapsed.

The interval is counted in crystal cycles.

When the count is done, a glitch-free two-leg clock mux hands the system clock over to the crystal. It turns the ring leg off before the crystal leg is turned on. The ring oscillator is then shut down. A status bit tells software which source is driving the clock. While the ring drives the clock, the two clock-divide bits are forced to read as divide-by-1. A divide value written in that window is kept and shows up as soon as the crystal has taken over. The watchdog clock is always taken straight from the crystal input.

All control is plain level signalling; there is no streaming data path. The stop request and the ring-select bit are synchronized into the crystal domain. Divide writes are single-cycle strobes in the crystal domain. The warm-up length `WARM_CYCLES` defaults to 65,536.

Top module: `stop_clk_switch`

## Requirements
- R1: `xtal_en` is 0 from the third crystal edge after `stop_in` rises until stop is released, and 1 at all other times.
- R2: In hold mode, `cpu_hold` stays 1 after `stop_in` falls and drops after exactly WARM_CYCLES+3 rising crystal edges: two synchronizer stages, one decision edge, then WARM_CYCLES counting edges.
- R3: In ring mode (`ring_sel_en`=1 when stop is released), `cpu_hold` drops 3 crystal edges after release. During warm-up, `ring_en` is 1 and `sys_clk` runs at the ring rate.
- R4: `cpu_hold` is 1 throughout stop, and `sys_clk` produces no edges while stopped.
- R5: Once the warm-up completes and the status bit reads 0, `ring_en` is 0 and `sys_clk` runs at the crystal rate.
- R6: `clk_on_ring` is 1 from the start of ring-mode warm-up until the ring leg of the mux has been switched off. It is 0 in hold mode and after the crystal takes over.
- R7: While `clk_on_ring` is 1, `div_eff` reads 2'b10 (divide-by-1).
- R8: `wdt_clk` always equals `xtal_clk`.
- R9: The mux never enables both legs together. Each leg is enabled through a synchronizer plus a falling-edge flop, so `sys_clk` never shows a pulse shorter than half a source period.
- R10: Re-entering stop during warm-up discards the partial count. The next release waits the full WARM_CYCLES+3 edges.
- R11: A `div_wr_data` value written while locked is held. It appears on `div_eff` in the same cycle `clk_on_ring` first reads 0. An unlocked write appears after the edge that captures it. The reset value of `div_eff` is 2'b10.
- R12: After reset: `cpu_hold`=0, `xtal_en`=1, `ring_en`=0, `clk_on_ring`=0, `div_eff`=2'b10, and `sys_clk` is driven by the crystal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| xtal_clk | input | 1 | Crystal clock |
| ring_clk | input | 1 | Internal ring-oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_in | input | 1 | 1 while the chip is in stop state |
| ring_sel_en | input | 1 | Software bit: 1 = run from ring during warm-up |
| div_wr_en | input | 1 | Divide-bit write strobe (crystal domain) |
| div_wr_data | input | 2 | Divide value to write |
| sys_clk | output | 1 | Glitch-free system clock |
| wdt_clk | output | 1 | Watchdog clock, always the crystal |
| xtal_en | output | 1 | Crystal oscillator enable |
| ring_en | output | 1 | Ring oscillator enable |
| cpu_hold | output | 1 | Holds CPU execution |
| clk_on_ring | output | 1 | Clock-source status, 1 = ring |
| div_eff | output | 2 | Effective clock-divide bits |

## Verification
Some rules are checked by the assertions on every crystal cycle:
- The two mux legs are never both enabled.
- The crystal enable is low whenever stop has been seen.
- The divide bits are forced while the status is set.
- Each leg's state agrees with the status bit.
- In hold mode, execution is released exactly WARM_CYCLES+1 cycles after the synchronized stop request drops.

Only the bench scenarios show the remaining behaviour. This covers the clock rate seen on `sys_clk` in each phase and the absence of runt pulses. It also covers a locked divide write surfacing at the handover, and a restarted count after stop is re-entered mid warm-up.

// File: rtl/scs_pkg.sv
package scs_pkg;
  typedef enum logic [1:0] {
    ST_RUN       = 2'd0,
    ST_STOP      = 2'd1,
    ST_WARM_RING = 2'd2,
    ST_WARM_HOLD = 2'd3
  } state_e;

  localparam logic [1:0] DIV_BY1 = 2'b10;
endpackage

// File: rtl/scs_sync.sv
module scs_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/scs_mux_leg.sv
// One leg of a break-before-make clock mux. The enable is formed on the
// rising edge and re-timed on the falling edge, so the gate opens or
// closes only while its own clock is low.
module scs_mux_leg #(
  parameter bit SYNC_WANT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic want,     // request for this leg
  input  logic other_s,  // other leg's enable, already in this domain
  output logic leg_on
);
  logic want_q;
  logic en_p;

  generate
    if (SYNC_WANT) begin : g_sync_want
      scs_sync #(.WIDTH(1)) u_want_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (want),
        .q     (want_q)
      );
    end else begin : g_direct_want
      assign want_q = want;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_p <= 1'b0;
    else        en_p <= want_q & ~other_s;
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) leg_on <= 1'b0;
    else        leg_on <= en_p;
  end
endmodule

// File: rtl/scs_warmup_fsm.sv
module scs_warmup_fsm
  import scs_pkg::*;
#(
  parameter int WARM_CYCLES = 65536
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stop_s,
  input  logic   ring_sel_s,
  output state_e state,
  output logic   want_x,
  output logic   want_r,
  output logic   hold,
  output logic   osc_x_en
);
  localparam int CW = (WARM_CYCLES > 2) ? $clog2(WARM_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WARM_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_RUN;
      cnt   <= '0;
    end else if (stop_s) begin
      state <= ST_STOP;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_STOP: begin
          state <= ring_sel_s ? ST_WARM_RING : ST_WARM_HOLD;
          cnt   <= '0;
        end
        ST_WARM_RING, ST_WARM_HOLD: begin
          if (cnt == LAST) state <= ST_RUN;
          else             cnt   <= cnt + CW'(1);
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    want_x   = (state == ST_RUN);
    want_r   = (state == ST_WARM_RING);
    hold     = (state == ST_STOP) || (state == ST_WARM_HOLD);
    osc_x_en = (state != ST_STOP);
  end
endmodule

// File: rtl/scs_div_lock.sv
module scs_div_lock
  import scs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       lock,
  input  logic       wr_en,
  input  logic [1:0] wr_data,
  output logic [1:0] div_out
);
  logic [1:0] div_q;

  // Writes are always captured; the lock only masks what is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     div_q <= DIV_BY1;
    else if (wr_en) div_q <= wr_data;
  end

  assign div_out = lock ? DIV_BY1 : div_q;
endmodule

// File: rtl/stop_clk_switch.sv
module stop_clk_switch
  import scs_pkg::*;
#(
  parameter int WARM_CYCLES = 65536
) (
  input  logic       xtal_clk,
  input  logic       ring_clk,
  input  logic       rst_n,
  input  logic       stop_in,
  input  logic       ring_sel_en,
  input  logic       div_wr_en,
  input  logic [1:0] div_wr_data,
  output logic       sys_clk,
  output logic       wdt_clk,
  output logic       xtal_en,
  output logic       ring_en,
  output logic       cpu_hold,
  output logic       clk_on_ring,
  output logic [1:0] div_eff
);
  logic [1:0] ctl_s;
  logic       stop_s, rsel_s;
  state_e     state;
  logic       want_x, want_r;
  logic       x_on, r_on;
  logic       r_on_x, x_on_r;

  scs_sync #(.WIDTH(2)) u_ctl_sync (
    .clk   (xtal_clk),
    .rst_n (rst_n),
    .d     ({stop_in, ring_sel_en}),
    .q     (ctl_s)
  );
  assign stop_s = ctl_s[1];
  assign rsel_s = ctl_s[0];

  scs_warmup_fsm #(.WARM_CYCLES(WARM_CYCLES)) u_fsm (
    .clk        (xtal_clk),
    .rst_n      (rst_n),
    .stop_s     (stop_s),
    .ring_sel_s (rsel_s),
    .state      (state),
    .want_x     (want_x),
    .want_r     (want_r),
    .hold       (cpu_hold),
    .osc_x_en   (xtal_en)
  );

  // Cross-domain views of each leg's enable.
  scs_sync #(.WIDTH(1)) u_ron_sync (
    .clk   (xtal_clk),
    .rst_n (rst_n),
    .d     (r_on),
    .q     (r_on_x)
  );

  scs_sync #(.WIDTH(1)) u_xon_sync (
    .clk   (ring_clk),
    .rst_n (rst_n),
    .d     (x_on),
    .q     (x_on_r)
  );

  scs_mux_leg #(.SYNC_WANT(1'b0)) u_leg_x (
    .clk     (xtal_clk),
    .rst_n   (rst_n),
    .want    (want_x),
    .other_s (r_on_x),
    .leg_on  (x_on)
  );

  scs_mux_leg #(.SYNC_WANT(1'b1)) u_leg_r (
    .clk     (ring_clk),
    .rst_n   (rst_n),
    .want    (want_r),
    .other_s (x_on_r),
    .leg_on  (r_on)
  );

  assign sys_clk     = (xtal_clk & x_on) | (ring_clk & r_on);
  assign wdt_clk     = xtal_clk;
  assign clk_on_ring = (state == ST_WARM_RING) | r_on_x;
  assign ring_en     = want_r | r_on_x;

  scs_div_lock u_div (
    .clk     (xtal_clk),
    .rst_n   (rst_n),
    .lock    (clk_on_ring),
    .wr_en   (div_wr_en),
    .wr_data (div_wr_data),
    .div_out (div_eff)
  );
endmodule

// File: rtl/scs_checker.sv
module scs_checker #(
  parameter int WARM_CYCLES = 65536
) (
  input logic       xtal_clk,
  input logic       rst_n,
  input logic       stop_s,
  input logic       x_on,
  input logic       r_on,
  input logic       xtal_en,
  input logic       cpu_hold,
  input logic       clk_on_ring,
  input logic [1:0] div_eff
);
  localparam int SW = $clog2(WARM_CYCLES + 3) + 1;
  localparam logic [SW-1:0] SAT     = SW'(WARM_CYCLES + 2);
  localparam logic [SW-1:0] RELEASE = SW'(WARM_CYCLES + 1);

  // Crystal cycles since the synchronized stop request dropped.
  logic [SW-1:0] since_exit;

  always_ff @(posedge xtal_clk or negedge rst_n) begin
    if (!rst_n)                 since_exit <= '0;
    else if (stop_s)            since_exit <= '0;
    else if (since_exit != SAT) since_exit <= since_exit + SW'(1);
  end

  p_legs_exclusive_r9: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    !(x_on && r_on));

  p_xtal_off_in_stop_r1: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    $past(stop_s) |-> !xtal_en);

  p_div_forced_r7: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    clk_on_ring |-> (div_eff == 2'b10));

  p_hold_release_time_r2: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    ($fell(cpu_hold) && !clk_on_ring) |-> (since_exit == RELEASE));

  p_xtal_leg_status_r5: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    x_on |-> !clk_on_ring);

  p_ring_leg_status_r6: assert property (@(posedge xtal_clk) disable iff (!rst_n)
    r_on |-> clk_on_ring);
endmodule

bind stop_clk_switch scs_checker #(.WARM_CYCLES(WARM_CYCLES)) u_scs_checker (
  .xtal_clk    (xtal_clk),
  .rst_n       (rst_n),
  .stop_s      (stop_s),
  .x_on        (x_on),
  .r_on        (r_on),
  .xtal_en     (xtal_en),
  .cpu_hold    (cpu_hold),
  .clk_on_ring (clk_on_ring),
  .div_eff     (div_eff)
);

// File: tb/tb_stop_clk_switch.sv
`timescale 1ns/1ps
module tb_stop_clk_switch;
  localparam int W = 32;

  logic       xtal_clk = 1'b0;
  logic       ring_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stop_in = 1'b0;
  logic       ring_sel_en = 1'b0;
  logic       div_wr_en = 1'b0;
  logic [1:0] div_wr_data = 2'b00;
  logic       sys_clk, wdt_clk, xtal_en, ring_en, cpu_hold, clk_on_ring;
  logic [1:0] div_eff;

  int tests = 0;
  int fails = 0;
  int sys_edges = 0;
  realtime t_rise = 0.0, t_fall = 0.0;
  real min_hi = 100.0, min_lo = 100.0;

  always #2.5 xtal_clk = ~xtal_clk;   // 200 MHz
  always #1.5 ring_clk = ~ring_clk;

  stop_clk_switch #(.WARM_CYCLES(W)) dut (
    .xtal_clk(xtal_clk), .ring_clk(ring_clk), .rst_n(rst_n),
    .stop_in(stop_in), .ring_sel_en(ring_sel_en),
    .div_wr_en(div_wr_en), .div_wr_data(div_wr_data),
    .sys_clk(sys_clk), .wdt_clk(wdt_clk), .xtal_en(xtal_en),
    .ring_en(ring_en), .cpu_hold(cpu_hold), .clk_on_ring(clk_on_ring),
    .div_eff(div_eff)
  );

  always @(posedge sys_clk) begin
    sys_edges++;
    t_rise = $realtime;
    if (t_fall > 0.0 && (t_rise - t_fall) < min_lo) min_lo = t_rise - t_fall;
  end
  always @(negedge sys_clk) begin
    t_fall = $realtime;
    if (t_rise > 0.0 && (t_fall - t_rise) < min_hi) min_hi = t_fall - t_rise;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_sys(output int n);
    int e0;
    e0 = sys_edges;
    repeat (10) @(negedge xtal_clk);
    n = sys_edges - e0;
  endtask

  task automatic measure_hold(output int n);
    n = 0;
    do begin
      @(posedge xtal_clk);
      n++;
      @(negedge xtal_clk);
    end while (cpu_hold && n < W + 40);
  endtask

  task automatic enter_stop(input logic rsel);
    int n;
    @(negedge xtal_clk);
    stop_in = 1'b1;
    ring_sel_en = rsel;
    repeat (8) @(negedge xtal_clk);
    chk(xtal_en == 1'b0, "R1 xtal_en in stop", xtal_en, 0);
    chk(cpu_hold == 1'b1, "R4 hold in stop", cpu_hold, 1);
    count_sys(n);
    chk(n == 0, "R4 sys_clk idle in stop", n, 0);
  endtask

  // Stimulus/expected table: {ring_sel, do_write, wr_data[1:0], exp_div[1:0]}
  localparam logic [5:0] VECS [5] = '{
    6'b11_00_00,
    6'b01_01_01,
    6'b11_11_11,
    6'b10_00_11,
    6'b00_00_11
  };

  task automatic run_vec(input logic [5:0] v);
    logic rsel, wr;
    logic [1:0] wd, ed;
    int n, k;
    rsel = v[5]; wr = v[4]; wd = v[3:2]; ed = v[1:0];
    enter_stop(rsel);
    stop_in = 1'b0;
    measure_hold(n);
    if (rsel) begin
      chk(n == 3, "R3 ring-mode release", n, 3);
      chk(clk_on_ring == 1'b1, "R6 status on ring", clk_on_ring, 1);
      chk(ring_en == 1'b1, "R3 ring_en during warm-up", ring_en, 1);
      chk(xtal_en == 1'b1, "R1 xtal_en after release", xtal_en, 1);
      chk(div_eff == 2'b10, "R7 divide forced", div_eff, 2);
      if (wr) begin
        div_wr_en = 1'b1; div_wr_data = wd;
        @(negedge xtal_clk);
        div_wr_en = 1'b0;
        chk(div_eff == 2'b10, "R11 locked write held back", div_eff, 2);
      end
      repeat (3) @(negedge xtal_clk);
      count_sys(n);
      chk(n >= 15 && n <= 18, "R3 sys_clk at ring rate", n, 17);
      k = 0;
      while (clk_on_ring && k < 200) begin
        @(negedge xtal_clk);
        k++;
      end
      chk(k >= W - 16, "R6 status held through warm-up", k, W - 16);
      chk(div_eff == ed, "R11 divide at handover", div_eff, ed);
      chk(ring_en == 1'b0, "R5 ring off after handover", ring_en, 0);
    end else begin
      chk(n == W + 3, "R2 hold-mode release", n, W + 3);
      chk(clk_on_ring == 1'b0, "R6 status in hold mode", clk_on_ring, 0);
      if (wr) begin
        div_wr_en = 1'b1; div_wr_data = wd;
        @(negedge xtal_clk);
        div_wr_en = 1'b0;
        chk(div_eff == wd, "R11 unlocked write", div_eff, wd);
      end
      chk(div_eff == ed, "R11 divide value", div_eff, ed);
    end
    repeat (2) @(negedge xtal_clk);
    count_sys(n);
    chk(n >= 9 && n <= 11, "R5 sys_clk at crystal rate", n, 10);
    chk(clk_on_ring == 1'b0, "R6 status after warm-up", clk_on_ring, 0);
  endtask

  initial begin
    repeat (100000) @(posedge xtal_clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    repeat (4) @(negedge xtal_clk);
    rst_n = 1'b1;
    repeat (3) @(negedge xtal_clk);
    // R12 reset state
    chk(cpu_hold == 1'b0, "R12 hold after reset", cpu_hold, 0);
    chk(xtal_en == 1'b1, "R12 xtal_en after reset", xtal_en, 1);
    chk(ring_en == 1'b0, "R12 ring_en after reset", ring_en, 0);
    chk(clk_on_ring == 1'b0, "R12 status after reset", clk_on_ring, 0);
    chk(div_eff == 2'b10, "R12 divide after reset", div_eff, 2);
    count_sys(n);
    chk(n >= 9 && n <= 11, "R12 crystal clock after reset", n, 10);

    // R8 watchdog clock follows the crystal
    for (int i = 0; i < 4; i++) begin
      @(posedge xtal_clk); #0.2;
      chk(wdt_clk == 1'b1, "R8 wdt_clk high", wdt_clk, 1);
      @(negedge xtal_clk); #0.2;
      chk(wdt_clk == 1'b0, "R8 wdt_clk low", wdt_clk, 0);
    end

    for (int i = 0; i < 5; i++) run_vec(VECS[i]);

    // R10 re-entering stop mid warm-up restarts the count
    enter_stop(1'b0);
    stop_in = 1'b0;
    repeat (12) @(negedge xtal_clk);
    chk(cpu_hold == 1'b1, "R10 still warming", cpu_hold, 1);
    enter_stop(1'b0);
    stop_in = 1'b0;
    measure_hold(n);
    chk(n == W + 3, "R10 full count after re-entry", n, W + 3);

    // R9 no runt pulses on sys_clk over the whole run
    chk(min_hi >= 1.4, "R9 min high width (ps)", int'(min_hi * 1000.0), 1500);
    chk(min_lo >= 1.4, "R9 min low width (ps)", int'(min_lo * 1000.0), 1500);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule